// File: doc/BRIEF.md
# Sequential Radix Digit Converter

This block turns an unsigned binary fixed-point number into a stream of digits in a radix chosen at run time, anywhere from 2 to 16. The integer and fraction widths of the input are parameters. The caller pulses `start_i` with the value, the radix and the number of fraction digits it wants. The block raises `busy_o` and then emits one digit per `digit_valid_o` strobe. Each digit comes out as a 4-bit binary value. `digit_is_frac_o` separates the integer digits from the fraction digits.

The whole part is taken apart by repeated division by the radix. Each division is a restoring shift-subtract loop that resolves one quotient bit per cycle. The remainders appear least significant first, so they are pushed onto a small stack and popped back most significant first. Division stops once the quotient becomes zero.

The fraction is then multiplied by the radix once per cycle. The bits of each product above the binary point form the next digit, and the bits below it carry into the next step. Such a fraction may never terminate, so the caller's count bounds the number of fraction digits. The final digit is truncated, not rounded. A single-cycle `done_o` pulse closes each conversion.

Top module: `rdx_conv`

## Requirements
- R1: After reset `busy_o`, `done_o` and `digit_valid_o` are all low.
- R2: The integer digits are the remainders of repeated division of the whole part by the radix, emitted most significant first with `digit_is_frac_o` low, each one smaller than the radix.
- R3: A whole part of zero yields exactly one integer digit, the value 0.
- R4: Fraction digits come from repeated multiplication of the fraction by the radix, taking the product's integer part as the digit and carrying the remainder. Exactly `frac_cnt_i` such digits are emitted with `digit_is_frac_o` high, none when the count is 0.
- R5: The radix is sampled at start and must lie in 2..16. `digit_o` carries the digit as an unsigned 4-bit binary number, 0 to radix-1.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last digit strobe, and `busy_o` is already low in that cycle.
- R7: A `start_i` pulse while `busy_o` is high has no effect on the digits being produced.
- R8: Digits are strobed only while `busy_o` is high, and no integer digit follows a fraction digit within one conversion.
- R9: The integer digit stream carries no leading zeros: its length is the minimal digit count of the whole part in the chosen radix (one for zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion (sampled only when idle) |
| value_i | input | INT_W+FRAC_W | Unsigned fixed-point input, whole part in the upper INT_W bits |
| radix_i | input | 5 | Target radix, 2 to 16 |
| frac_cnt_i | input | FCNT_W | Number of fraction digits to produce |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse after the last digit |
| digit_valid_o | output | 1 | Digit strobe |
| digit_o | output | 4 | Digit value |
| digit_is_frac_o | output | 1 | High for fraction digits, low for integer digits |

## Verification
The assertions assume that a radix presented with an accepted start lies between 2 and 16. Every other check (digit below the radix, stack never overflowing or underflowing, divider remainder below its divisor) relies on that assumption. The stimulus table and the directed cases only ever use radices in that range, including both end points. The stack depth also assumes that the whole part has no more than INT_W base-2 digits, which holds for every value the input width can carry. The start pulse issued in the middle of a conversion uses a legal radix as well, so the checks stay sound while it is being ignored.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_EMIT,
        ST_FRAC,
        ST_FIN
    } rdx_state_e;

    localparam int unsigned RADIX_W = 5;
    localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/rdx_div.sv
module rdx_div #(
    parameter int unsigned NUM_W = 8,
    parameter int unsigned DEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    localparam int unsigned CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
    } div_t;

    div_t cur_q, nxt_d;
    logic [DEN_W:0] trial_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        trial_d    = {cur_q.rem, cur_q.quo[NUM_W-1]};
        if (go_i) begin
            nxt_d.run = 1'b1;
            nxt_d.cnt = CW'(NUM_W);
            nxt_d.quo = num_i;
            nxt_d.rem = '0;
            nxt_d.den = den_i;
        end else if (cur_q.run) begin
            if (trial_d >= {1'b0, cur_q.den}) begin
                nxt_d.rem = DEN_W'(trial_d - {1'b0, cur_q.den});
                nxt_d.quo = {cur_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                nxt_d.rem = trial_d[DEN_W-1:0];
                nxt_d.quo = {cur_q.quo[NUM_W-2:0], 1'b0};
            end
            nxt_d.cnt = cur_q.cnt - 1'b1;
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.run  = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign done_o = cur_q.done;
    assign quo_o  = cur_q.quo;
    assign rem_o  = cur_q.rem;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < cur_q.den)); // R2
    AST_NO_GO_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.run |-> !go_i); // R2
endmodule

// File: rtl/rdx_lifo.sv
module rdx_lifo #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [W-1:0]               din_i,
    output logic [W-1:0]               top_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } lifo_t;

    lifo_t cur_q, nxt_d;
    logic [AW-1:0] wr_idx_d, top_idx_d;

    always_comb begin
        nxt_d     = cur_q;
        wr_idx_d  = AW'(cur_q.cnt);
        top_idx_d = AW'(cur_q.cnt - 1'b1);
        if (push_i) begin
            nxt_d.mem[wr_idx_d] = din_i;
            nxt_d.cnt           = cur_q.cnt + 1'b1;
        end else if (pop_i) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign top_o = cur_q.mem[top_idx_d];
    assign cnt_o = cur_q.cnt;

    AST_LIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cur_q.cnt < CW'(DEPTH))); // R2
    AST_LIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cur_q.cnt != '0)); // R2
    AST_LIFO_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R2
endmodule

// File: rtl/rdx_conv.sv
module rdx_conv
    import rdx_pkg::*;
#(
    parameter int unsigned INT_W  = 8,
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned FCNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [INT_W+FRAC_W-1:0] value_i,
    input  logic [4:0]              radix_i,
    input  logic [FCNT_W-1:0]       frac_cnt_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    digit_valid_o,
    output logic [3:0]              digit_o,
    output logic                    digit_is_frac_o
);
    localparam int unsigned PW    = FRAC_W + RADIX_W;
    localparam int unsigned DEPTH = INT_W;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        rdx_state_e         state;
        logic [FRAC_W-1:0]  frac;
        logic [RADIX_W-1:0] radix;
        logic [FCNT_W-1:0]  fleft;
        logic [DIGIT_W-1:0] dig;
        logic               dvalid;
        logic               dfrac;
        logic               done;
    } conv_t;

    conv_t cur_q, nxt_d;

    logic               div_go_d;
    logic [INT_W-1:0]   div_num_d;
    logic [RADIX_W-1:0] div_den_d;
    logic               div_done;
    logic [INT_W-1:0]   div_quo;
    logic [RADIX_W-1:0] div_rem;
    logic               push_d, pop_d;
    logic [DIGIT_W-1:0] lifo_top;
    logic [CW-1:0]      lifo_cnt;
    logic [PW-1:0]      prod_d;

    rdx_div #(.NUM_W(INT_W), .DEN_W(RADIX_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go_d),
        .num_i  (div_num_d),
        .den_i  (div_den_d),
        .done_o (div_done),
        .quo_o  (div_quo),
        .rem_o  (div_rem)
    );

    rdx_lifo #(.W(DIGIT_W), .DEPTH(DEPTH)) u_lifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_d),
        .pop_i  (pop_d),
        .din_i  (div_rem[DIGIT_W-1:0]),
        .top_o  (lifo_top),
        .cnt_o  (lifo_cnt)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.dvalid = 1'b0;
        nxt_d.done   = 1'b0;
        div_go_d     = 1'b0;
        push_d       = 1'b0;
        pop_d        = 1'b0;
        div_num_d    = div_quo;
        div_den_d    = cur_q.radix;
        prod_d       = PW'(cur_q.frac) * PW'(cur_q.radix);
        case (cur_q.state)
            ST_IDLE: begin
                div_num_d = value_i[INT_W+FRAC_W-1:FRAC_W];
                div_den_d = radix_i;
                if (start_i) begin
                    div_go_d    = 1'b1;
                    nxt_d.frac  = value_i[FRAC_W-1:0];
                    nxt_d.radix = radix_i;
                    nxt_d.fleft = frac_cnt_i;
                    nxt_d.state = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    push_d = 1'b1;
                    if (div_quo == '0) nxt_d.state = ST_EMIT;
                    else               div_go_d    = 1'b1;
                end
            end
            ST_EMIT: begin
                pop_d        = 1'b1;
                nxt_d.dig    = lifo_top;
                nxt_d.dvalid = 1'b1;
                nxt_d.dfrac  = 1'b0;
                if (lifo_cnt == CW'(1))
                    nxt_d.state = (cur_q.fleft != '0) ? ST_FRAC : ST_FIN;
            end
            ST_FRAC: begin
                nxt_d.dig    = prod_d[FRAC_W +: DIGIT_W];
                nxt_d.frac   = prod_d[FRAC_W-1:0];
                nxt_d.dvalid = 1'b1;
                nxt_d.dfrac  = 1'b1;
                nxt_d.fleft  = cur_q.fleft - 1'b1;
                if (cur_q.fleft == FCNT_W'(1)) nxt_d.state = ST_FIN;
            end
            ST_FIN: begin
                nxt_d.done  = 1'b1;
                nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o          = (cur_q.state != ST_IDLE);
    assign done_o          = cur_q.done;
    assign digit_valid_o   = cur_q.dvalid;
    assign digit_o         = cur_q.dig;
    assign digit_is_frac_o = cur_q.dfrac;

    AST_RADIX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> (radix_i >= 5'd2 && radix_i <= 5'd16)); // R5
    AST_DIGIT_BELOW_RADIX: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid_o |-> ({1'b0, digit_o} < cur_q.radix)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_AFTER_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(digit_valid_o) && !busy_o)); // R6
    AST_DIGIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid_o |-> busy_o); // R8
    AST_FRAC_STAYS_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_valid_o && $past(digit_valid_o && digit_is_frac_o)) |-> digit_is_frac_o); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cur_q.state != ST_FIN) |=> $stable(cur_q.radix)); // R7
endmodule

// File: tb/rdx_conv_bench.sv
module rdx_conv_bench;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 12;
    localparam int FCNT_W = 4;
    localparam int VW     = INT_W + FRAC_W;
    localparam int NV     = 8;

    localparam logic [VW-1:0] TV_VAL [NV] = '{
        20'h697C7, 20'h00ABC, 20'hFF800, 20'hC8400,
        20'h3B123, 20'h07FFF, 20'hFFFFF, 20'h01000};
    localparam logic [4:0] TV_RDX [NV] = '{5'd5, 5'd10, 5'd2, 5'd16, 5'd7, 5'd3, 5'd16, 5'd2};
    localparam logic [3:0] TV_CNT [NV] = '{4'd5, 4'd4, 4'd8, 4'd3, 4'd6, 4'd15, 4'd3, 4'd0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [VW-1:0] value_i = '0;
    logic [4:0] radix_i = 5'd10;
    logic [FCNT_W-1:0] frac_cnt_i = '0;
    logic busy_o, done_o, digit_valid_o, digit_is_frac_o;
    logic [3:0] digit_o;

    always #2.5 clk = ~clk;

    rdx_conv #(.INT_W(INT_W), .FRAC_W(FRAC_W), .FCNT_W(FCNT_W)) u_rdx_conv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
        .radix_i(radix_i), .frac_cnt_i(frac_cnt_i), .busy_o(busy_o),
        .done_o(done_o), .digit_valid_o(digit_valid_o), .digit_o(digit_o),
        .digit_is_frac_o(digit_is_frac_o));

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int got_n = 0;
    int done_cnt = 0;
    int last_dig_cyc = 0;
    int done_cyc = 0;
    int busy_at_done = 0;
    int got_d [64];
    int got_f [64];
    int exp_d [64];
    int exp_f [64];
    int exp_n;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (digit_valid_o) begin
            if (got_n < 64) begin
                got_d[got_n] = int'(digit_o);
                got_f[got_n] = int'(digit_is_frac_o);
            end
            got_n = got_n + 1;
            last_dig_cyc = cyc;
        end
        if (done_o) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
            busy_at_done = int'(busy_o);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [VW-1:0] v, input int r, input int n);
        int w;
        int f;
        int tmp [16];
        int k;
        w = int'(v[VW-1:FRAC_W]);
        f = int'(v[FRAC_W-1:0]);
        k = 0;
        do begin
            tmp[k] = w % r;
            w = w / r;
            k = k + 1;
        end while (w != 0);
        exp_n = 0;
        for (int i = k - 1; i >= 0; i--) begin
            exp_d[exp_n] = tmp[i];
            exp_f[exp_n] = 0;
            exp_n = exp_n + 1;
        end
        for (int i = 0; i < n; i++) begin
            f = f * r;
            exp_d[exp_n] = f >> FRAC_W;
            exp_f[exp_n] = 1;
            f = f & ((1 << FRAC_W) - 1);
            exp_n = exp_n + 1;
        end
    endtask

    task automatic run(input logic [VW-1:0] v, input logic [4:0] r,
                       input logic [3:0] n, input bit poke);
        int guard;
        got_n = 0;
        done_cnt = 0;
        @(negedge clk);
        value_i = v; radix_i = r; frac_cnt_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            value_i = 20'h07000; radix_i = 5'd16; frac_cnt_i = 4'd1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            @(negedge clk);
            guard = guard + 1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string req);
        bit same;
        int bad_i;
        same = (got_n == exp_n);
        bad_i = -1;
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
            if (got_d[i] != exp_d[i] || got_f[i] != exp_f[i]) begin
                same = 1'b0;
                if (bad_i < 0) bad_i = i;
            end
        end
        check(got_n == exp_n, req, "digit count", got_n, exp_n);
        if (bad_i >= 0)
            check(1'b0, req, "digit/flag at index", got_d[bad_i] * 2 + got_f[bad_i],
                  exp_d[bad_i] * 2 + exp_f[bad_i]);
        else
            check(same || got_n != exp_n, req, "digit stream", 1, 1);
        check(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
        check(done_cyc == last_dig_cyc + 1, "R6", "done cycle after last digit",
              done_cyc, last_dig_cyc + 1);
        check(busy_at_done == 0, "R6", "busy during done", busy_at_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !digit_valid_o, "R1", "idle outputs after reset",
              int'({busy_o, done_o, digit_valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !digit_valid_o, "R1", "idle outputs after release",
              int'({busy_o, done_o, digit_valid_o}), 0);

        for (int t = 0; t < NV; t++) begin
            model(TV_VAL[t], int'(TV_RDX[t]), int'(TV_CNT[t]));
            run(TV_VAL[t], TV_RDX[t], TV_CNT[t], 1'b0);
            compare("R2 R4 R5 R9");
        end

        // R2 R9: 105 in radix 5 with no fraction must give 4,1,0
        run(20'h69000, 5'd5, 4'd0, 1'b0);
        check(got_n == 3, "R9", "digit count 105 radix 5", got_n, 3);
        check(got_d[0] == 4 && got_d[1] == 1 && got_d[2] == 0 && got_f[2] == 0,
              "R2", "digits of 105 radix 5", got_d[0] * 100 + got_d[1] * 10 + got_d[2], 410);

        // R4: 105.5 in radix 10 with three fraction digits gives 1,0,5 . 5,0,0
        run(20'h69800, 5'd10, 4'd3, 1'b0);
        check(got_n == 6 && got_d[3] == 5 && got_d[4] == 0 && got_d[5] == 0 && got_f[3] == 1,
              "R4", "fraction of 105.5 radix 10", got_d[3] * 100 + got_d[4] * 10 + got_d[5], 500);
        check(got_d[0] == 1 && got_d[1] == 0 && got_d[2] == 5 && got_f[0] == 0,
              "R2", "integer of 105.5 radix 10", got_d[0] * 100 + got_d[1] * 10 + got_d[2], 105);

        // R3: zero whole part emits one digit 0
        run(20'h00800, 5'd16, 4'd0, 1'b0);
        check(got_n == 1 && got_d[0] == 0 && got_f[0] == 0, "R3", "zero whole part",
              got_n * 100 + got_d[0], 100);

        // R7: a start mid-conversion is ignored
        model(20'hC8400, 3, 4);
        run(20'hC8400, 5'd3, 4'd4, 1'b1);
        compare("R7");

        // R8: integer digits all precede fraction digits
        model(20'hFF123, 2, 6);
        run(20'hFF123, 5'd2, 4'd6, 1'b0);
        compare("R8");
        begin
            int seen_frac;
            int order_bad;
            seen_frac = 0;
            order_bad = 0;
            for (int i = 0; i < got_n && i < 64; i++) begin
                if (got_f[i] == 1) seen_frac = 1;
                else if (seen_frac == 1) order_bad = 1;
            end
            check(order_bad == 0, "R8", "integer after fraction", order_bad, 0);
        end
        check(!busy_o && !digit_valid_o, "R8", "quiet after done",
              int'({busy_o, digit_valid_o}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule